// File: doc/BRIEF.md
# Receive Byte-Packing FIFO

This block takes the byte stream coming out of a serial shift engine and collects the bytes into 32-bit entries of a small receive FIFO. A 32-bit read port then drains the FIFO. Packing does not depend on the serial word width, so every full entry holds four bytes. The earliest byte goes in the top lane and the latest in the bottom lane. When the requested byte count ends with fewer than four bytes collected, the end-of-request marker closes the entry early. That partial entry is stored with a 3-bit count of its valid bytes. Its bytes are aligned to the low end, with the earliest byte in the highest valid lane.

The head entry is presented on the read port ahead of the pop (show-ahead). A pop strobe removes it at the next clock edge. The block reports a 6-bit fill level and raises a receive interrupt while that level is at or above a programmable trigger level. An enable input gates buffering and a flush input empties everything. Two sticky flags record overflow and underflow misuse.

The packer is a four-state machine, and each state counts the bytes held for the current entry. `PK_IDLE` (none held) moves to `PK_HAVE1` on a byte without the marker, or stays and pushes a one-byte entry if the marker is present. `PK_HAVE1` moves to `PK_HAVE2` on a byte, or returns to `PK_IDLE` and pushes a two-byte entry on a marked byte. `PK_HAVE2` moves to `PK_HAVE3` on a byte, or returns to `PK_IDLE` and pushes a three-byte entry on a marked byte. `PK_HAVE3` always returns to `PK_IDLE` on the next byte and pushes a four-byte entry. A flush sends any state to `PK_IDLE`.

Top module: `rx_pack_fifo`

## Requirements
- R1: After reset, fill_level is 0, head_data is 0, head_count is 0, and both ovf_flag and unf_flag are 0.
- R2: Four bytes accepted without the marker form one entry with head_count 4. The first byte is in bits 31:24, the second in 23:16, the third in 15:8 and the fourth in 7:0. The entry is counted in fill_level from the clock edge that accepts the fourth byte.
- R3: A byte accepted with rx_last high closes the entry after 1 to 4 bytes, and head_count holds that byte count. The first byte sits at bit (head_count-1)*8, later bytes follow toward bit 0, and unused upper bits read 0. A marker on the fourth byte gives one entry with head_count 4.
- R4: Entries leave in arrival order. fill_level is the 6-bit number of stored entries. A pop with a non-empty FIFO removes the head at that clock edge.
- R5: rx_irq is high exactly when fill_level is greater than or equal to trig_lvl.
- R6: A flush pulse empties the FIFO, discards bytes already collected for an unfinished entry, and clears ovf_flag and unf_flag. A byte presented in the same cycle as the flush is dropped.
- R7: While buf_en is low, incoming bytes are ignored. No entry is pushed and the packer does not advance.
- R8: An entry completed while the FIFO holds DEPTH entries and no pop is present is dropped. ovf_flag is then set and stays set until flush. Stored entries are unchanged.
- R9: A pop while the FIFO is empty sets unf_flag, which stays set until flush. While empty, head_data and head_count read 0.
- R10: When an entry completes in the same cycle as a pop of a non-empty FIFO, both take effect and fill_level stays the same. This holds even when the FIFO is full, and ovf_flag stays clear in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_en | input | 1 | Buffering enable; bytes are ignored while low |
| flush | input | 1 | Empties FIFO, packer and flags |
| trig_lvl | input | 6 | Interrupt trigger level |
| rx_valid | input | 1 | A received byte is presented |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the current request |
| pop | input | 1 | Remove the head entry |
| head_data | output | 32 | Head entry data, 0 when empty |
| head_count | output | 3 | Valid bytes in head entry, 0 when empty |
| fill_level | output | 6 | Number of stored entries |
| rx_irq | output | 1 | Fill level at or above trigger |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
A pop and the completion of an entry can happen in the same cycle. This is the collision that matters most. The bench provokes it by presenting the closing byte in the same cycle as a pop strobe. It does this once with the FIFO full and once with it empty. With the FIFO full, the fill level must not change, no overflow may be flagged, and draining must show the new entry last. With the FIFO empty, the pop must be flagged as an underflow while the new entry still lands, giving a fill level of one.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;
    localparam int LVL_W = 6;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int CNT_W = 3;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
    } rx_entry_t;
endpackage

// File: rtl/rx_byte_packer.sv
module rx_byte_packer
    import rx_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_last,
    output logic              push_o,
    output rx_entry_t         entry_o
);
    localparam int ACC_W = WORD_W - BYTE_W;

    typedef enum logic [1:0] {PK_IDLE, PK_HAVE1, PK_HAVE2, PK_HAVE3} pk_state_t;

    pk_state_t state, nxt;
    logic [ACC_W-1:0] acc;
    logic take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PK_IDLE;
        else if (flush)
            state <= PK_IDLE;
        else
            state <= nxt;
    end

    // collected bytes, low aligned, cleared whenever an entry closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (flush)
            acc <= '0;
        else if (take)
            acc <= push_o ? '0 : {acc[ACC_W-BYTE_W-1:0], byte_in};
    end

    // next state and outputs
    always_comb begin
        take          = enable && byte_vld && !flush;
        nxt           = state;
        push_o        = 1'b0;
        entry_o.data  = {acc, byte_in};
        entry_o.cnt   = '0;
        unique case (state)
            PK_IDLE: begin
                if (take) begin
                    if (byte_last) begin
                        push_o      = 1'b1;
                        entry_o.cnt = CNT_W'(1);
                    end else begin
                        nxt = PK_HAVE1;
                    end
                end
            end
            PK_HAVE1: begin
                if (take) begin
                    if (byte_last) begin
                        push_o      = 1'b1;
                        entry_o.cnt = CNT_W'(2);
                        nxt         = PK_IDLE;
                    end else begin
                        nxt = PK_HAVE2;
                    end
                end
            end
            PK_HAVE2: begin
                if (take) begin
                    if (byte_last) begin
                        push_o      = 1'b1;
                        entry_o.cnt = CNT_W'(3);
                        nxt         = PK_IDLE;
                    end else begin
                        nxt = PK_HAVE3;
                    end
                end
            end
            PK_HAVE3: begin
                if (take) begin
                    push_o      = 1'b1;
                    entry_o.cnt = CNT_W'(4);
                    nxt         = PK_IDLE;
                end
            end
            default: nxt = PK_IDLE;
        endcase
    end

    // R2: a push without the marker is always a complete word
    p_full_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && !byte_last) |-> (entry_o.cnt == CNT_W'(4)));

    // R3: partial entries keep their top lane empty
    p_low_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && entry_o.cnt != CNT_W'(4)) |-> (entry_o.data[WORD_W-1 -: BYTE_W] == '0));

    // R7: nothing is pushed while disabled
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !push_o);
endmodule

// File: rtl/rx_entry_store.sv
module rx_entry_store
    import rx_pack_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output logic [LVL_W-1:0] level,
    output logic             ovf,
    output logic             unf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    rx_entry_t mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic empty, full, do_pop, do_push;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        empty   = (level == '0);
        full    = (level == FULL_LVL);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= adv(wr_ptr);
            if (do_pop)  rd_ptr <= adv(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
            if (push && !do_push) ovf <= 1'b1;
            if (pop && empty)     unf <= 1'b1;
        end
    end

    always_comb begin
        head = empty ? '0 : mem[rd_ptr];
    end

    // R4: the level never exceeds the storage
    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R10: without flush the level moves by at most one per cycle
    p_level_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (level == $past(level)) || (level == $past(level) + 1'b1)
                   || (level + 1'b1 == $past(level)));

    // R8: overflow is sticky until flush
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);

    // R9: underflow is sticky until flush
    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !flush) |=> unf);

    // R6: flush leaves an empty store
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0) && !ovf && !unf);
endmodule

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo
    import rx_pack_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_en,
    input  logic              flush,
    input  logic [LVL_W-1:0]  trig_lvl,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_last,
    input  logic              pop,
    output logic [WORD_W-1:0] head_data,
    output logic [CNT_W-1:0]  head_count,
    output logic [LVL_W-1:0]  fill_level,
    output logic              rx_irq,
    output logic              ovf_flag,
    output logic              unf_flag
);
    rx_entry_t pk_entry, hd_entry;
    logic pk_push;

    rx_byte_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (buf_en),
        .flush     (flush),
        .byte_vld  (rx_valid),
        .byte_in   (rx_byte),
        .byte_last (rx_last),
        .push_o    (pk_push),
        .entry_o   (pk_entry)
    );

    rx_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (pk_push),
        .push_entry (pk_entry),
        .pop        (pop),
        .head       (hd_entry),
        .level      (fill_level),
        .ovf        (ovf_flag),
        .unf        (unf_flag)
    );

    always_comb begin
        head_data  = hd_entry.data;
        head_count = hd_entry.cnt;
        rx_irq     = (fill_level >= trig_lvl);
    end

    // R9: an empty FIFO shows a blank head
    p_empty_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> (head_count == '0) && (head_data == '0));

    // R4: a stored entry always carries 1 to 4 bytes
    p_head_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level != '0) |-> (head_count >= CNT_W'(1)) && (head_count <= CNT_W'(4)));
endmodule

// File: tb/tb_rx_pack_fifo.sv
`timescale 1ns/1ps
module tb_rx_pack_fifo;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_en = 1'b1;
    logic flush = 1'b0;
    logic [5:0] trig_lvl = 6'd63;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_last = 1'b0;
    logic pop = 1'b0;
    logic [31:0] head_data;
    logic [2:0] head_count;
    logic [5:0] fill_level;
    logic rx_irq, ovf_flag, unf_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rx_pack_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .flush(flush),
        .trig_lvl(trig_lvl), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_last(rx_last), .pop(pop), .head_data(head_data),
        .head_count(head_count), .fill_level(fill_level), .rx_irq(rx_irq),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic last);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_last = last;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) send(w[i*8 +: 8], 1'b0);
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fill", fill_level, 0);
        chk("R1 data", head_data, 0);
        chk("R1 count", head_count, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 unf", unf_flag, 0);
    endtask

    task automatic t_full_word();
        send_word(32'hDEADBEEF);
        chk("R2 fill", fill_level, 1);
        chk("R2 data", head_data, 32'hDEADBEEF);
        chk("R2 count", head_count, 4);
        do_pop();
        chk("R4 pop empties", fill_level, 0);
    endtask

    task automatic t_partial();
        send(8'h11, 0); send(8'h22, 0); send(8'h33, 1);
        send(8'h44, 1);
        send(8'h55, 0); send(8'h66, 1);
        send(8'h71, 0); send(8'h72, 0); send(8'h73, 0); send(8'h74, 1);
        chk("R3 fill", fill_level, 4);
        chk("R3 three data", head_data, 32'h00112233);
        chk("R3 three count", head_count, 3);
        do_pop();
        chk("R3 one data", head_data, 32'h00000044);
        chk("R3 one count", head_count, 1);
        do_pop();
        chk("R3 two data", head_data, 32'h00005566);
        chk("R3 two count", head_count, 2);
        do_pop();
        chk("R3 marked fourth data", head_data, 32'h71727374);
        chk("R3 marked fourth count", head_count, 4);
        do_pop();
        chk("R3 drained", fill_level, 0);
    endtask

    task automatic t_order_irq();
        trig_lvl = 6'd3;
        send_word(32'h01020304);
        send_word(32'h05060708);
        chk("R5 irq below", rx_irq, 0);
        send_word(32'h090A0B0C);
        chk("R4 fill three", fill_level, 3);
        chk("R5 irq at level", rx_irq, 1);
        chk("R4 first out", head_data, 32'h01020304);
        do_pop();
        chk("R5 irq drops", rx_irq, 0);
        chk("R4 second out", head_data, 32'h05060708);
        do_pop();
        chk("R4 third out", head_data, 32'h090A0B0C);
        do_pop();
        trig_lvl = 6'd0;
        @(negedge clk);
        chk("R5 zero trigger", rx_irq, 1);
        trig_lvl = 6'd63;
    endtask

    task automatic t_flush();
        send_word(32'hCAFEF00D);
        send(8'hEE, 0); send(8'hEF, 0);
        do_flush();
        chk("R6 flush fill", fill_level, 0);
        chk("R6 flush head", head_count, 0);
        @(negedge clk);
        flush = 1'b1; rx_valid = 1'b1; rx_byte = 8'h99; rx_last = 1'b0;
        @(negedge clk);
        flush = 1'b0; rx_valid = 1'b0;
        send_word(32'hA1A2A3A4);
        chk("R6 partial discarded", head_data, 32'hA1A2A3A4);
        chk("R6 one entry", fill_level, 1);
        do_pop();
    endtask

    task automatic t_enable();
        buf_en = 1'b0;
        send(8'h5A, 0); send(8'h5B, 1);
        chk("R7 disabled fill", fill_level, 0);
        buf_en = 1'b1;
        send_word(32'h10203040);
        chk("R7 clean word", head_data, 32'h10203040);
        chk("R7 fill", fill_level, 1);
        do_pop();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) send_word(32'h100 + i);
        chk("R8 full", fill_level, DEPTH);
        chk("R8 no ovf yet", ovf_flag, 0);
        send_word(32'hBADBAD00);
        chk("R8 fill held", fill_level, DEPTH);
        chk("R8 ovf set", ovf_flag, 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R8 content", head_data, 32'h100 + i);
            do_pop();
        end
        chk("R8 dropped", fill_level, 0);
        chk("R8 sticky", ovf_flag, 1);
        do_flush();
        chk("R6 ovf cleared", ovf_flag, 0);
    endtask

    task automatic t_underflow();
        do_pop();
        chk("R9 unf set", unf_flag, 1);
        chk("R9 data zero", head_data, 0);
        chk("R9 fill", fill_level, 0);
        @(negedge clk);
        chk("R9 sticky", unf_flag, 1);
        do_flush();
        chk("R6 unf cleared", unf_flag, 0);
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < DEPTH; i++) send_word(32'h200 + i);
        send(8'h61, 0); send(8'h62, 0); send(8'h63, 0);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h64; pop = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; pop = 1'b0;
        chk("R10 full fill kept", fill_level, DEPTH);
        chk("R10 no ovf", ovf_flag, 0);
        chk("R10 head advanced", head_data, 32'h201);
        for (int i = 1; i < DEPTH; i++) do_pop();
        chk("R10 new entry last", head_data, 32'h61626364);
        do_pop();
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h7E; rx_last = 1'b1; pop = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; pop = 1'b0;
        chk("R10 empty push lands", fill_level, 1);
        chk("R10 empty pop flagged", unf_flag, 1);
        chk("R10 empty data", head_data, 32'h0000007E);
        do_flush();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_word();
        t_partial();
        t_order_irq();
        t_flush();
        t_enable();
        t_overflow();
        t_underflow();
        t_same_cycle();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule